// File: doc/BRIEF.md
# Six-Code JK Sequence Counter

This block is a 3-bit synchronous counter. It does not count in binary. It walks a fixed loop of six codes and moves one step on each rising clock edge while counting is enabled. Each state bit is kept in its own JK-type storage cell. A shared excitation stage works out the J and K input of every cell from the present state, so all three bits change on the same edge.

Two codes are never part of the loop: 100 and 111. If the counter ever holds one of them, the next enabled edge sends it to 000. A synchronous clear input forces 000 on the next edge. The chip's asynchronous active-low reset loads a parameterised start code, which is 000 by default.

Top module: `seqctr_jk`

## Requirements
- R1: While `rst_n` is low, `state` equals the parameter `RST_STATE` (default 000). It takes that value without waiting for a clock edge and keeps it for as long as `rst_n` stays low.
- R2: If `clr` is high at a rising edge, `state` becomes 000 after that edge, whatever the value of `en`.
- R3: If `en` is high and `clr` is low, each rising edge moves `state` (bit order Q2 Q1 Q0, Q2 the MSB) along the loop 000, 010, 011, 110, 101, 001 and then back to 000. The loop repeats without end.
- R4: If `en` and `clr` are both low, `state` does not change at a rising edge. This also holds when `state` is an unused code.
- R5: The unused codes 100 and 111 go to 000 on the next edge where `en` is high.
- R6: Each bit follows JK rules, with J and K coming from the present state:
  - J=0, K=0 holds the bit.
  - J=0, K=1 clears it.
  - J=1, K=0 sets it.
  - J=1, K=1 toggles it.
  - When `en` and `clr` are both low, every bit receives J=K=0.
- R7: All bits that change on a step change together on the same rising edge. No intermediate code is visible after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads `RST_STATE` |
| clr | input | 1 | Synchronous active-high clear to 000; takes priority over `en` |
| en | input | 1 | Count enable |
| state | output | 3 | Present code, Q2 Q1 Q0 |

## Verification
The main instance uses the default `RST_STATE` of 000. It runs through the loop several times, with enable gaps and clears placed between steps. Two more instances are built with `RST_STATE` set to 100 and to 111. Reset is the only way to place the counter in an unused code through its ports, so these instances are what make it possible to test the hold, clear and recovery behaviour from those codes. A sample taken one nanosecond after a two-bit step shows that the bits do not ripple.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

  localparam int unsigned CW = 3;

  typedef logic [CW-1:0] code_t;

  localparam code_t C_A = 3'b000;
  localparam code_t C_B = 3'b010;
  localparam code_t C_C = 3'b011;
  localparam code_t C_D = 3'b110;
  localparam code_t C_E = 3'b101;
  localparam code_t C_F = 3'b001;

  // Target code for one enabled step; unused codes fall back to C_A.
  function automatic code_t successor(code_t cur);
    code_t nxt;
    case (cur)
      C_A:     nxt = C_B;
      C_B:     nxt = C_C;
      C_C:     nxt = C_D;
      C_D:     nxt = C_E;
      C_E:     nxt = C_F;
      C_F:     nxt = C_A;
      default: nxt = C_A;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jk_cell.sv
module jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic j,
  input  logic k,
  output logic q
);

  logic q_nxt;

  always_comb begin
    case ({j, k})
      2'b00:   q_nxt = q;
      2'b01:   q_nxt = 1'b0;
      2'b10:   q_nxt = 1'b1;
      default: q_nxt = ~q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/seqctr_excite.sv
module seqctr_excite
  import seqctr_pkg::*;
(
  input  code_t cur,
  input  logic  clr,
  input  logic  adv,
  output code_t j,
  output code_t k
);

  code_t tgt;

  always_comb begin
    tgt = successor(cur);
    for (int b = 0; b < CW; b++) begin
      if (clr) begin
        j[b] = 1'b0;
        k[b] = 1'b1;
      end else if (!adv) begin
        j[b] = 1'b0;
        k[b] = 1'b0;
      end else if (cur[b]) begin
        j[b] = 1'b0;
        k[b] = ~tgt[b];
      end else begin
        j[b] = tgt[b];
        k[b] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/seqctr_jk.sv
module seqctr_jk
  import seqctr_pkg::*;
#(
  parameter logic [2:0] RST_STATE = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  output logic [2:0] state
);

  code_t jv;
  code_t kv;

  seqctr_excite u_exc (
    .cur (state),
    .clr (clr),
    .adv (en),
    .j   (jv),
    .k   (kv)
  );

  for (genvar g = 0; g < CW; g++) begin : g_bit
    jk_cell #(
      .RST_VAL (RST_STATE[g])
    ) u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .j     (jv[g]),
      .k     (kv[g]),
      .q     (state[g])
    );
  end

endmodule

// File: rtl/seqctr_jk_chk.sv
module seqctr_jk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       en,
  input logic [2:0] state,
  input logic [2:0] j,
  input logic [2:0] k
);

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> state == 3'b000); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(state)); // R4

  AST_STEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && state == 3'b000) |=> state == 3'b010); // R3

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && state == 3'b001) |=> state == 3'b000); // R3

  AST_STEP_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && state == 3'b110) |=> state == 3'b101); // R7

  AST_UNUSED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (state == 3'b100 || state == 3'b111)) |=> state == 3'b000); // R5

  AST_JK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |-> (j == 3'b000 && k == 3'b000)); // R6

  for (genvar g = 0; g < 3; g++) begin : g_jk
    AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (j[g] && k[g]) |=> state[g] != $past(state[g])); // R6
    AST_JK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (j[g] && !k[g]) |=> state[g]); // R6
    AST_JK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (!j[g] && k[g]) |=> !state[g]); // R6
  end

endmodule

bind seqctr_jk seqctr_jk_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .clr   (clr),
  .en    (en),
  .state (state),
  .j     (jv),
  .k     (kv)
);

// File: tb/tb_seqctr_jk.sv
`timescale 1ns/1ps
module tb_seqctr_jk;

  localparam int NV = 23;
  // Each entry: {clr, en, expected state after the edge}
  localparam logic [4:0] VECS [0:NV-1] = '{
    5'b01_010, 5'b01_011, 5'b00_011, 5'b00_011, 5'b01_110,
    5'b01_101, 5'b01_001, 5'b01_000, 5'b01_010, 5'b01_011,
    5'b01_110, 5'b11_000, 5'b01_010, 5'b01_011, 5'b10_000,
    5'b00_000, 5'b01_010, 5'b01_011, 5'b01_110, 5'b01_101,
    5'b00_101, 5'b01_001, 5'b01_000
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       en = 1'b0;
  logic       clr_a = 1'b0;
  logic       en_a = 1'b0;
  logic [2:0] state;
  logic [2:0] st4;
  logic [2:0] st7;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  seqctr_jk dut (.clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .state(state));
  seqctr_jk #(.RST_STATE(3'b100)) dut_u4 (.clk(clk), .rst_n(rst_n), .clr(clr_a), .en(en_a), .state(st4));
  seqctr_jk #(.RST_STATE(3'b111)) dut_u7 (.clk(clk), .rst_n(rst_n), .clr(clr_a), .en(en_a), .state(st7));

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: state=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(state, 3'b000, "R1");
    check(st4, 3'b100, "R1");
    check(st7, 3'b111, "R1");
    rst_n = 1'b1;

    // Unused codes: hold while idle, then recover
    @(negedge clk);
    check(st4, 3'b100, "R4");
    check(st7, 3'b111, "R4");
    en_a = 1'b1;
    @(negedge clk);
    check(st4, 3'b000, "R5");
    check(st7, 3'b000, "R5");
    @(negedge clk);
    check(st4, 3'b010, "R3");
    en_a = 1'b0;

    // Main vector walk from 000
    for (int i = 0; i < NV; i++) begin
      clr = VECS[i][4];
      en  = VECS[i][3];
      @(negedge clk);
      check(state, VECS[i][2:0], VECS[i][4] ? "R2" : (VECS[i][3] ? "R3" : "R4"));
    end

    // Two-bit step seen right after the edge (no ripple): 000->010->011->110->101
    en = 1'b1;
    repeat (3) @(negedge clk);
    check(state, 3'b110, "R3");
    @(posedge clk);
    #1;
    check(state, 3'b101, "R7");
    @(negedge clk);
    en = 1'b0;

    // Asynchronous reset between edges
    #2 rst_n = 1'b0;
    #1;
    check(state, 3'b000, "R1");
    check(st4, 3'b100, "R1");
    @(negedge clk);
    check(st7, 3'b111, "R1");
    rst_n = 1'b1;

    // Clear from unused codes while enable is low
    clr_a = 1'b1;
    @(negedge clk);
    check(st4, 3'b000, "R2");
    check(st7, 3'b000, "R2");
    clr_a = 1'b0;
    check(state, 3'b000, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule